// File: doc/BRIEF.md
# Rotation-Recompute Checked Lightweight Feistel Encryption Core

This block encrypts one 48-bit block with a 96-bit-key lightweight Feistel cipher over 36 rounds. The block is held as two 24-bit words, and a single round datapath is shared across all rounds. Every round is evaluated twice on that datapath. The first pass uses the plain operands. The second pass uses both state words and the round key rotated left by a fixed amount; its result is rotated back to the right and compared with the stored first-pass result. Any difference sets a sticky error flag.

A second check protects the feedback path. From round 1 onward, the state word pair that actually enters the round is compared with a separate copy of the previous round's output, and a mismatch also sets the flag. The key schedule stays outside the block. The core shows the round it is working on, and the surrounding logic supplies the matching 24-bit round key. A fault-injection input lets a bench corrupt the datapath on purpose to prove that both checks work.

Top module: `simon_rero_core`

## Requirements
- R1: After synchronous reset, `done` and `err` are 0, `rnd_idx` is 0 and `ct_out` is 0.
- R2: Bits 47:24 of `pt_in` and `ct_out` are the left word x, and bits 23:0 are the right word y. Each round maps (x, y) to (y ^ f(x) ^ k, x), with f(x) = (rotl1(x) & rotl8(x)) ^ rotl2(x), and `ct_out` is the result of 36 such rounds.
- R3: The key for round i is read from `rkey` while `rnd_idx` equals i. `rnd_idx` counts from 0 to 35 and holds each value for two cycles, one per pass.
- R4: `done` is high for exactly one cycle, 72 clock edges after the edge that accepts `start`.
- R5: `ct_out` holds the ciphertext while `done` is high and keeps it while the core is idle.
- R6: With `fault_sel`=0, a nonzero `fault_mask` is XORed onto the f output on the first pass of the rounds where it is driven. `err` rises on the edge that ends that round's second pass (edge 2r+2 for round r), and the ciphertext carries the corruption.
- R7: With `fault_sel`=1, the mask acts only on the second, rotated pass. `err` rises at edge 2r+2 and the ciphertext is still correct.
- R8: `err` stays high until a new `start` is accepted, and that acceptance clears it.
- R9: A `start` that arrives while a run is in progress is ignored. The run and its ciphertext are unchanged.
- R10: Every rotation amount from 1 to 23 produces the same ciphertext and the same `done` timing.
- R11: With `fault_sel`=2, the mask is XORed onto the left word of the round input on both passes. For round r of 1 or more, the feedback check raises `err` at edge 2r+1. For round 0 no flag is raised, because no earlier output exists to compare with. `fault_sel`=3 turns injection off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin encrypting `pt_in` (accepted when not busy) |
| pt_in | input | 48 | Plaintext block {left, right} |
| rkey | input | 24 | Round key for the round shown on `rnd_idx` |
| fault_sel | input | 2 | Injection point: 0 first-pass f, 1 second-pass f, 2 round input, 3 off |
| fault_mask | input | 24 | XOR mask applied at the selected point |
| rnd_idx | output | 6 | Index of the round being computed |
| ct_out | output | 48 | Ciphertext block {left, right} |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky fault flag |

## Verification
The bench builds two copies side by side, one with the default rotation of 5 and one with 23. The two share plaintext, keys and injection, so they must agree bit for bit. Using the largest rotation puts the wrap-around of the rotated operands at the far end of the word. In that case nearly every bit of the second pass lands in a different position from the first, which would expose any rotation or un-rotation slip. The injection cases cover faults in round 0, a middle round and the last round, on each pass and on the feedback path. Among them is the one undetectable case, where the fault sits on round 0's input.

// File: rtl/simon_rero_pkg.sv
package simon_rero_pkg;
    localparam int WORD_W = 24;
    localparam int BLK_W  = 2 * WORD_W;
    localparam int ROUNDS = 36;
    localparam int RND_W  = $clog2(ROUNDS);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t left;
        word_t right;
    } blk_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_NORM = 2'd1,
        PH_ROT  = 2'd2,
        PH_DONE = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        INJ_NORM_F = 2'd0,
        INJ_ROT_F  = 2'd1,
        INJ_INPUT  = 2'd2,
        INJ_OFF    = 2'd3
    } inj_t;

    function automatic word_t rotl(word_t x, int unsigned s);
        return word_t'((x << s) | (x >> (WORD_W - s)));
    endfunction

    function automatic word_t rotr(word_t x, int unsigned s);
        return word_t'((x >> s) | (x << (WORD_W - s)));
    endfunction

    function automatic word_t mix_f(word_t x);
        return (rotl(x, 1) & rotl(x, 8)) ^ rotl(x, 2);
    endfunction
endpackage

// File: rtl/simon_round_dp.sv
module simon_round_dp
    import simon_rero_pkg::*;
#(
    parameter int ROT_AMT = 5
) (
    input  blk_t  in_blk,
    input  word_t key,
    input  logic  rot_pass,
    input  word_t f_mask,
    output blk_t  out_blk
);
    localparam int unsigned ROT_U = ROT_AMT;

    word_t op_x, op_y, op_k, fval, nl, nr;

    // operand encoder: plain on the first pass, rotated left on the second
    always_comb begin
        op_x = rot_pass ? rotl(in_blk.left,  ROT_U) : in_blk.left;
        op_y = rot_pass ? rotl(in_blk.right, ROT_U) : in_blk.right;
        op_k = rot_pass ? rotl(key,          ROT_U) : key;
        fval = mix_f(op_x) ^ f_mask;
        nl   = op_y ^ fval ^ op_k;
        nr   = op_x;
        out_blk.left  = rot_pass ? rotr(nl, ROT_U) : nl;
        out_blk.right = rot_pass ? rotr(nr, ROT_U) : nr;
    end
endmodule

// File: rtl/simon_ctrl.sv
module simon_ctrl
    import simon_rero_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output phase_t           phase,
    output logic [RND_W-1:0] rnd,
    output logic             accept
);
    localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

    assign accept = start && (phase == PH_IDLE || phase == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            rnd   <= '0;
        end else if (accept) begin
            phase <= PH_NORM;
            rnd   <= '0;
        end else begin
            case (phase)
                PH_NORM: phase <= PH_ROT;
                PH_ROT: begin
                    if (rnd == LAST) begin
                        phase <= PH_DONE;
                    end else begin
                        rnd   <= rnd + 1'b1;
                        phase <= PH_NORM;
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3
    round_held_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_NORM) |=> (phase == PH_ROT && $stable(rnd)));

    // R3
    round_range_chk: assert property (@(posedge clk) disable iff (rst)
        rnd <= LAST);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE) |=> (phase != PH_DONE));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ROT && rnd != LAST) |=> (phase == PH_NORM));
endmodule

// File: rtl/simon_rero_core.sv
module simon_rero_core
    import simon_rero_pkg::*;
#(
    parameter int ROT_AMT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BLK_W-1:0]  pt_in,
    input  logic [WORD_W-1:0] rkey,
    input  logic [1:0]        fault_sel,
    input  logic [WORD_W-1:0] fault_mask,
    output logic [RND_W-1:0]  rnd_idx,
    output logic [BLK_W-1:0]  ct_out,
    output logic              done,
    output logic              err
);
    phase_t phase;
    logic   accept;
    inj_t   inj;
    blk_t   pt_reg, work, link_ref, first_res, applied, dp_out;
    word_t  f_mask;
    logic   busy, link_bad;

    assign inj = inj_t'(fault_sel);

    simon_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .phase  (phase),
        .rnd    (rnd_idx),
        .accept (accept)
    );

    assign busy = (phase == PH_NORM) || (phase == PH_ROT);

    // round input select: fresh plaintext for round 0, feedback afterwards
    always_comb begin
        applied = (rnd_idx == '0) ? pt_reg : work;
        if (inj == INJ_INPUT) applied.left = applied.left ^ fault_mask;
        f_mask = '0;
        if ((inj == INJ_NORM_F && phase == PH_NORM) ||
            (inj == INJ_ROT_F  && phase == PH_ROT))
            f_mask = fault_mask;
    end

    assign link_bad = busy && (rnd_idx != '0) && (applied != link_ref);

    simon_round_dp #(.ROT_AMT(ROT_AMT)) u_dp (
        .in_blk   (applied),
        .key      (rkey),
        .rot_pass (phase == PH_ROT),
        .f_mask   (f_mask),
        .out_blk  (dp_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pt_reg    <= '0;
            work      <= '0;
            link_ref  <= '0;
            first_res <= '0;
            err       <= 1'b0;
        end else begin
            if (accept) begin
                pt_reg <= pt_in;
                err    <= 1'b0;
            end
            if (phase == PH_NORM) first_res <= dp_out;
            if (phase == PH_ROT) begin
                work     <= first_res;
                link_ref <= first_res;
                if (dp_out != first_res) err <= 1'b1;
            end
            if (link_bad) err <= 1'b1;
        end
    end

    assign ct_out = work;
    assign done   = (phase == PH_DONE);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !accept) |=> err);

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !err);

    // R5
    ct_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !start) |=> $stable(ct_out));

    // R11
    link_flag_chk: assert property (@(posedge clk) disable iff (rst)
        link_bad |=> err);
endmodule

// File: tb/simon_rero_core_bench.sv
module simon_rero_core_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [47:0] pt_in = '0;
    logic [1:0]  fault_sel = 2'd3;
    logic [23:0] inj_m = '0;
    int          inj_tgt = 0;
    logic [23:0] rkey_a, rkey_b, mask_a, mask_b;
    logic [5:0]  rnd_a, rnd_b;
    logic [47:0] ct_a, ct_b;
    logic        done_a, done_b, err_a, err_b;
    logic [23:0] keys [0:35];
    int          checks = 0;
    int          errors = 0;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        rkey_a = keys[rnd_a];
        rkey_b = keys[rnd_b];
        mask_a = (int'(rnd_a) == inj_tgt) ? inj_m : 24'h0;
        mask_b = (int'(rnd_b) == inj_tgt) ? inj_m : 24'h0;
    end

    simon_rero_core u_simon_rero_core (
        .clk(clk), .rst(rst), .start(start), .pt_in(pt_in), .rkey(rkey_a),
        .fault_sel(fault_sel), .fault_mask(mask_a), .rnd_idx(rnd_a),
        .ct_out(ct_a), .done(done_a), .err(err_a));

    simon_rero_core #(.ROT_AMT(23)) u_simon_rero_core_r23 (
        .clk(clk), .rst(rst), .start(start), .pt_in(pt_in), .rkey(rkey_b),
        .fault_sel(fault_sel), .fault_mask(mask_b), .rnd_idx(rnd_b),
        .ct_out(ct_b), .done(done_b), .err(err_b));

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] rl(logic [23:0] x, int s);
        return 24'((x << s) | (x >> (24 - s)));
    endfunction

    function automatic logic [47:0] ref_ct(logic [47:0] pt, int mode, int tgt,
                                           logic [23:0] m);
        logic [23:0] x, y, t, nx;
        x = pt[47:24];
        y = pt[23:0];
        for (int i = 0; i < 36; i++) begin
            if (mode == 2 && i == tgt) x = x ^ m;
            t = (rl(x, 1) & rl(x, 8)) ^ rl(x, 2);
            if (mode == 0 && i == tgt) t = t ^ m;
            nx = y ^ t ^ keys[i];
            y  = x;
            x  = nx;
        end
        return {x, y};
    endfunction

    task automatic set_keys(input logic [31:0] seed);
        for (int i = 0; i < 36; i++)
            keys[i] = 24'((seed * 32'h9E3779B1) ^ (i * 32'h01234567) ^ (i << 13));
    endtask

    // one encryption; mode 3 = no fault; poke = extra start while busy
    task automatic run(input logic [47:0] pt, input int mode, input int tgt,
                       input logic [23:0] m, input bit poke, input string tag);
        logic [47:0] exp_ct;
        int          err_edge;
        exp_ct = ref_ct(pt, mode, tgt, m);
        err_edge = 0;
        if (m != 0 && (mode == 0 || mode == 1)) err_edge = 2 * tgt + 2;
        if (m != 0 && mode == 2 && tgt > 0)     err_edge = 2 * tgt + 1;
        fault_sel = 2'(mode);
        inj_m = m;
        inj_tgt = tgt;
        @(negedge clk);
        pt_in = pt;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        pt_in = ~pt;
        for (int c = 1; c <= 74; c++) begin
            bit exp_err;
            @(posedge clk);
            @(negedge clk);
            exp_err = (err_edge != 0) && (c >= err_edge);
            // R4 one-cycle done at edge 72
            chk(done_a == (c == 72), {tag, " R4 done"}, 64'(done_a), 64'(c == 72));
            chk(done_b == (c == 72), {tag, " R10 done rot23"}, 64'(done_b), 64'(c == 72));
            // R6 R7 R8 R11 error flag timing
            chk(err_a == exp_err, {tag, " R6/R7/R11 err"}, 64'(err_a), 64'(exp_err));
            chk(err_b == exp_err, {tag, " R10 err rot23"}, 64'(err_b), 64'(exp_err));
            if (c <= 72) begin
                // R3 round index sequence
                chk(int'(rnd_a) == ((c < 72) ? c / 2 : 35), {tag, " R3 rnd_idx"},
                    64'(rnd_a), 64'((c < 72) ? c / 2 : 35));
            end
            if (c >= 72) begin
                // R2 R5 ciphertext valid at done and held afterwards
                chk(ct_a == exp_ct, {tag, " R2/R5 ct"}, 64'(ct_a), 64'(exp_ct));
                chk(ct_b == exp_ct, {tag, " R10 ct rot23"}, 64'(ct_b), 64'(exp_ct));
            end
            if (poke && c == 10) begin
                pt_in = 48'h0123456789AB;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        fault_sel = 2'd3;
        inj_m = '0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_keys(32'd1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(done_a == 1'b0 && err_a == 1'b0, "R1 done/err", {62'd0, done_a, err_a}, 64'd0);
        chk(rnd_a == 6'd0, "R1 rnd_idx", 64'(rnd_a), 64'd0);
        chk(ct_a == 48'd0 && ct_b == 48'd0, "R1 ct_out", 64'(ct_a), 64'd0);

        // R2 plain encryption, two patterns
        run(48'h6565_6877_6F6E, 3, 0, 24'h0, 1'b0, "R2 a");
        set_keys(32'd2);
        run(48'hFFFFFF_000000, 3, 0, 24'h0, 1'b0, "R2 b");
        // R6 first-pass fault mid and first round
        run(48'h13579B_2468AC, 0, 7, 24'h000400, 1'b0, "R6 mid");
        run(48'hA5A5A5_5A5A5A, 0, 0, 24'h800000, 1'b0, "R6 r0");
        // R8 next clean run clears the flag
        run(48'h000001_000000, 3, 0, 24'h0, 1'b0, "R8 clear");
        // R7 second-pass fault in last round
        set_keys(32'd7);
        run(48'hDEADBE_EFCAFE, 1, 35, 24'h800001, 1'b0, "R7 last");
        // R11 input fault, detectable and round-0 case
        run(48'h112233_445566, 2, 12, 24'h0F0000, 1'b0, "R11 r12");
        run(48'h112233_445566, 2, 0, 24'h0F0000, 1'b0, "R11 r0");
        // R9 start while busy ignored
        run(48'h0BADF0_0DBEEF, 3, 0, 24'h0, 1'b1, "R9 poke");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule